// File: doc/BRIEF.md
# Retriggerable Variable-Width Command Pulse Generator

This block turns a train of short command strobes into one continuous output pulse. The pulse width depends on how many commands arrive and how closely they are spaced. When the output is low, a command raises it and loads a timeout counter with its full value (49 ticks of a 1 ms time base by default). While the output is high, each further command reloads the counter to the full value, so the pulse stretches. When the counter runs out on a tick, the output falls.

Commands spaced 23 ms apart therefore give a pulse of (n-1)·23 + 49 ms for n commands. On the first cycle after the pulse ends, the block issues a one-cycle done strobe. That strobe can start the clearing of a downstream command register. The 1 ms tick is an input; the block never derives time from the clock count.

Top module: `vepw_pulse_gen`

## Requirements
- R1: A command strobe while the output is low raises `pulseOut` on the next clock edge and loads the timer with TIMEOUT_TICKS (default 49).
- R2: While `pulseOut` is low, `msTick` has no effect: the output stays low and no done strobe appears until a command arrives.
- R3: A command strobe while `pulseOut` is high reloads the timer to the full TIMEOUT_TICKS, and `pulseOut` stays high without a gap. With n commands spaced 23 ticks apart, the output stays high for exactly (n-1)·23 + 49 ticks counted from the first command.
- R4: Only `msTick` advances the timer. `pulseOut` falls on the clock edge that samples the TIMEOUT_TICKS-th tick after the last command.
- R5: A command strobe in the same cycle as the expiring tick counts as a retrigger. `pulseOut` stays high, no done strobe is issued, and a fresh full timeout follows.
- R6: `doneStrobe` is high for exactly one cycle: the first cycle in which `pulseOut` is low after having been high. At no other time is it high.
- R7: An active-low asynchronous reset `rstN` forces `pulseOut` and `doneStrobe` low and clears the timer. After reset, the output rises only after a command.
- R8: If a command and a tick arrive in the same cycle while the timer holds more than one tick, the command wins. The timer reloads to the full value and is not decremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle strobe marking each 1 ms interval |
| cmdStrobe | input | 1 | One-cycle strobe for each received variable-width command |
| pulseOut | output | 1 | Command output pulse |
| doneStrobe | output | 1 | One-cycle strobe on the cycle after the pulse ends |

## Verification
A corrupted timer value shows up at `pulseOut` only when the pulse ends. A wrong reload or decrement moves the falling edge by one or more ticks, so a width measurement in ticks catches it at the end of the affected pulse. A control state that disagrees with the timer appears at once as a high output with no pending command, or a missing or doubled done strobe. Comparing the outputs against a behavioural model on every clock exposes these faults within the pulse in which they occur. The expiry-cycle retrigger gets its own case, because there a wrong priority drops the output for a single cycle.

// File: rtl/vepw_pkg.sv
package vepw_pkg;

  // Strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic load;  // reload timer with full timeout
    logic dec;   // step timer down by one tick
  } vepwCtrlT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vepwStateT;

endpackage

// File: rtl/vepw_timer_dp.sv
module vepw_timer_dp
  import vepw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 49,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  vepwCtrlT ctrl,
  output logic     lastCount,
  output logic     timerZero
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] remainCnt;
  logic [CNT_W-1:0] remainNext;

  always_comb begin
    remainNext = remainCnt;
    if (ctrl.load) begin
      remainNext = FULL_CNT;
    end else if (ctrl.dec && (remainCnt != '0)) begin
      remainNext = remainCnt - ONE_CNT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remainCnt <= '0;
    end else begin
      remainCnt <= remainNext;
    end
  end

  assign lastCount = (remainCnt == ONE_CNT);
  assign timerZero = (remainCnt == '0);

  // R3 / R8: a load always leaves the full timeout behind
  p_reload_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (remainCnt == FULL_CNT));

  // R4: a decrement removes exactly one tick
  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.dec && !ctrl.load && (remainCnt != '0)) |=> (remainCnt == $past(remainCnt) - ONE_CNT));

  // R4: with no strobe the timer holds its value
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.dec && !ctrl.load) |=> $stable(remainCnt));

endmodule

// File: rtl/vepw_ctrl.sv
module vepw_ctrl
  import vepw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStrobe,
  input  logic     msTick,
  input  logic     lastCount,
  output vepwCtrlT ctrl,
  output logic     pulseOut,
  output logic     doneStrobe
);

  vepwStateT state;
  vepwStateT stateNext;
  logic      expire;
  logic      doneNext;

  always_comb begin
    ctrl.load = cmdStrobe;
    ctrl.dec  = (state == ST_RUN) && msTick && !cmdStrobe;
    expire    = ctrl.dec && lastCount;
    stateNext = state;
    doneNext  = 1'b0;
    if (cmdStrobe) begin
      stateNext = ST_RUN;
    end else if (expire) begin
      stateNext = ST_IDLE;
      doneNext  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      doneStrobe <= 1'b0;
    end else begin
      state      <= stateNext;
      doneStrobe <= doneNext;
    end
  end

  assign pulseOut = (state == ST_RUN);

  // R1: a command always leaves the output high
  p_cmd_raises_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> pulseOut);

  // R2: idle with no command stays idle
  p_idle_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseOut && !cmdStrobe) |=> (!pulseOut && !doneStrobe));

  // R4: the output only falls on a tick
  p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut && !msTick) |=> pulseOut);

  // R6: done is a single-cycle strobe following a fall
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  p_done_after_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOut) |-> doneStrobe);

endmodule

// File: rtl/vepw_pulse_gen.sv
module vepw_pulse_gen
  import vepw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 49
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic cmdStrobe,
  output logic pulseOut,
  output logic doneStrobe
);

  vepwCtrlT ctrl;
  logic     lastCount;
  logic     timerZero;

  vepw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStrobe  (cmdStrobe),
    .msTick     (msTick),
    .lastCount  (lastCount),
    .ctrl       (ctrl),
    .pulseOut   (pulseOut),
    .doneStrobe (doneStrobe)
  );

  vepw_timer_dp #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .lastCount (lastCount),
    .timerZero (timerZero)
  );

  // R4 / R7: control state and timer contents agree
  p_pulse_matches_timer_r4: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut == !timerZero);

  // R5: a command on the expiring tick keeps the pulse alive
  p_expiry_retrig_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut && lastCount && msTick && cmdStrobe) |=> (pulseOut && !doneStrobe));

endmodule

// File: tb/test_vepw_pulse_gen.sv
module test_vepw_pulse_gen;

  localparam int TMO = 49;
  localparam int GAP = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic cmdStrobe = 1'b0;
  logic pulseOut;
  logic doneStrobe;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCnt = 0;

  // behavioural reference state
  int  mRemain = 0;
  bit  mPulse = 0;
  bit  mDone = 0;
  string phase = "R7 reset";

  always #5 clk = ~clk;

  vepw_pulse_gen #(.TIMEOUT_TICKS(TMO)) i_vepw_pulse_gen (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .cmdStrobe  (cmdStrobe),
    .pulseOut   (pulseOut),
    .doneStrobe (doneStrobe)
  );

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycleCnt);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(string tag, logic actual, logic expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic modelEdge(bit c, bit t);
    mDone = 0;
    if (c) begin
      mRemain = TMO;
      mPulse = 1;
    end else if (mPulse && t) begin
      mRemain--;
      if (mRemain == 0) begin
        mPulse = 0;
        mDone = 1;
      end
    end
  endtask

  // called at a falling edge: drive, clock, model, compare at next falling edge
  task automatic step(bit c, bit t);
    cmdStrobe = c;
    msTick = t;
    @(posedge clk);
    modelEdge(c, t);
    @(negedge clk);
    cmdStrobe = 1'b0;
    msTick = 1'b0;
    check({phase, " pulse"}, pulseOut, mPulse);
    check({phase, " done"}, doneStrobe, mDone);
  endtask

  // three quiet cycles then one tick cycle (optionally with a command)
  task automatic tickPeriod(bit cmdOnTick);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    step(cmdOnTick, 1'b1);
  endtask

  task automatic measure(string tag, int nCmd, int expTicks);
    int ticks = 0;
    phase = tag;
    step(1'b1, 1'b0);
    while (pulseOut && ticks < 400) begin
      tickPeriod(1'b0);
      ticks++;
      if (pulseOut && (ticks % GAP == 0) && (ticks / GAP < nCmd)) step(1'b1, 1'b0);
    end
    testsRun++;
    if (ticks != expTicks) begin
      testsFailed++;
      $display("FAIL %s width: actual=%0d expected=%0d", tag, ticks, expTicks);
    end
    step(1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    // R7: outputs low during reset
    check("R7 reset pulse", pulseOut, 1'b0);
    check("R7 reset done", doneStrobe, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: ticks while idle do nothing
    phase = "R2 idle ticks";
    for (int i = 0; i < 5; i++) tickPeriod(1'b0);
    check("R2 still low", pulseOut, 1'b0);

    // R1, R4, R6: single command gives 49 ticks
    measure("R1 R4 single", 1, TMO);

    // R3: n commands 23 ticks apart
    measure("R3 two cmds", 2, GAP + TMO);
    measure("R3 three cmds", 3, 2 * GAP + TMO);

    // R8: command and tick together mid-pulse reloads
    phase = "R8 cmd with tick";
    step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) tickPeriod(1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < TMO - 1; i++) tickPeriod(1'b0);
    check("R8 high one tick before end", pulseOut, 1'b1);
    tickPeriod(1'b0);
    check("R8 low after full reload", pulseOut, 1'b0);
    step(1'b0, 1'b0);

    // R5: command on the expiring tick
    phase = "R5 expiry retrigger";
    step(1'b1, 1'b0);
    for (int i = 0; i < TMO - 1; i++) tickPeriod(1'b0);
    tickPeriod(1'b1);
    check("R5 pulse held", pulseOut, 1'b1);
    check("R5 no done", doneStrobe, 1'b0);
    for (int i = 0; i < TMO; i++) tickPeriod(1'b0);
    check("R5 falls after fresh timeout", pulseOut, 1'b0);
    step(1'b0, 1'b0);

    // R7: reset in the middle of a pulse
    phase = "R7 mid reset";
    step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) tickPeriod(1'b0);
    rstN = 1'b0;
    mRemain = 0; mPulse = 0; mDone = 0;
    #1;
    check("R7 async pulse low", pulseOut, 1'b0);
    check("R7 async done low", doneStrobe, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    phase = "R7 after reset";
    for (int i = 0; i < 3; i++) tickPeriod(1'b0);
    check("R7 stays low", pulseOut, 1'b0);
    measure("R7 fresh pulse", 1, TMO);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule